// File: doc/BRIEF.md
# Product Code Entry and Matcher

This block takes a four-digit decimal product code from three button pulses: one steps the digit being edited, one confirms it, and one abandons the entry. After every confirmed digit it compares the code so far against a constant table of twelve products. The resulting candidate mask narrows while the code is still being typed, so a display can highlight every product that could still match.

When all four digits single out one product, the block reports that product's index and price in cents. It then moves to a quantity step. There the step button picks a quantity from 1 to 9, and the confirm button issues a one-cycle add-to-cart request that carries the index and the quantity. A complete code that matches no product gives a one-cycle invalid pulse and the entry starts again. The button inputs are expected to be clean, debounced, single-cycle pulses.

Top module: `prodcode_entry`

## Requirements
- R1: After reset, cur_digit is 0, digit_pos is 0, match_mask is all ones, hit is 0, qty is 0, hit_index is 0, hit_price is 0, invalid is 0 and add_valid is 0.
- R2: While entering a code, a btn_inc pulse advances cur_digit by one on the next cycle, and 9 wraps to 0.
- R3: A btn_next pulse at position k (0 = most significant digit) clears match_mask bit p on the next cycle unless decimal digit k of product p's code equals cur_digit. It also advances digit_pos and sets cur_digit to 0.
- R4: Confirming the fourth digit when a product's full code matches raises hit on the next cycle. At the same time match_mask becomes one-hot on that product, hit_index and hit_price show its index and price, qty becomes 1, and digit_pos becomes 0.
- R5: Confirming the fourth digit when no product matches raises invalid for exactly one cycle. At the same time digit_pos and cur_digit become 0, match_mask becomes all ones and hit stays 0.
- R6: While hit is 1, a btn_inc pulse advances qty by one on the next cycle, and 9 wraps to 1.
- R7: While hit is 1, a btn_next pulse raises add_valid for exactly one cycle with add_index equal to the matched index and add_qty equal to the quantity held. In that same cycle hit drops to 0 and match_mask becomes all ones.
- R8: A btn_clear pulse in any state gives, on the next cycle, digit_pos 0, cur_digit 0, match_mask all ones, hit 0 and qty 0, with no add_valid and no invalid pulse.
- R9: When pulses coincide, btn_clear takes priority over btn_next, and btn_next takes priority over btn_inc. The lower-priority button has no effect in that cycle.
- R10: The table by index 0..11 holds codes 1234, 1243, 1324, 1342, 2134, 2143, 2314, 3124, 3142, 3412, 4123, 4133 with prices in cents 50, 125, 199, 240, 315, 399, 450, 525, 610, 735, 850, 995.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_inc | input | 1 | Step pulse: next digit value or next quantity |
| btn_next | input | 1 | Confirm pulse: accept digit or quantity |
| btn_clear | input | 1 | Abandon pulse: restart code entry |
| cur_digit | output | 4 | Digit value being edited |
| digit_pos | output | 2 | Position of the digit being edited, 0 first |
| match_mask | output | 12 | One bit per product still matching the prefix |
| hit | output | 1 | A product is identified; quantity step active |
| hit_index | output | 4 | Matched product index (valid with hit) |
| hit_price | output | 10 | Matched product price in cents (valid with hit) |
| qty | output | 4 | Quantity being chosen |
| invalid | output | 1 | One-cycle pulse: complete code matched nothing |
| add_valid | output | 1 | One-cycle add-to-cart request |
| add_index | output | 4 | Product index of the request |
| add_qty | output | 4 | Quantity of the request |

## Verification
A wrong stored digit position or a wrong table digit shows as a wrong match_mask in the cycle after the confirm pulse. Each confirmation is checked at that point against a prefix mask computed from the decimal codes, and every two-digit prefix is swept. A wrong phase or a stale index shows within one cycle of the fourth confirm as a wrong hit, index or price, and one cycle after the quantity confirm as a missing or mislabelled add request. Wrap, priority and clear faults show as wrong digit, quantity or mask values one cycle after the pulse.

// File: rtl/prodcode_pkg.sv
package prodcode_pkg;

    localparam int N_PROD  = 12;
    localparam int N_DIG   = 4;
    localparam int DIG_W   = 4;
    localparam int CODE_W  = DIG_W * N_DIG;
    localparam int PRICE_W = 10;
    localparam int IDX_W   = $clog2(N_PROD);
    localparam int POS_W   = $clog2(N_DIG);
    localparam int QTY_W   = 4;

    typedef logic [DIG_W-1:0]  digit_t;
    typedef logic [N_PROD-1:0] mask_t;

    typedef enum logic {PH_CODE = 1'b0, PH_QTY = 1'b1} phase_e;

    // Codes held as packed decimal digits, first digit in the top nibble.
    function automatic logic [CODE_W-1:0] prod_code(int p);
        case (p)
            0:       return 16'h1234;
            1:       return 16'h1243;
            2:       return 16'h1324;
            3:       return 16'h1342;
            4:       return 16'h2134;
            5:       return 16'h2143;
            6:       return 16'h2314;
            7:       return 16'h3124;
            8:       return 16'h3142;
            9:       return 16'h3412;
            10:      return 16'h4123;
            default: return 16'h4133;
        endcase
    endfunction

    function automatic logic [PRICE_W-1:0] prod_price(int p);
        case (p)
            0:       return 10'd50;
            1:       return 10'd125;
            2:       return 10'd199;
            3:       return 10'd240;
            4:       return 10'd315;
            5:       return 10'd399;
            6:       return 10'd450;
            7:       return 10'd525;
            8:       return 10'd610;
            9:       return 10'd735;
            10:      return 10'd850;
            default: return 10'd995;
        endcase
    endfunction

    // Digit k of product p, k = 0 being the first digit entered.
    function automatic digit_t prod_digit(int p, int k);
        logic [CODE_W-1:0] c;
        c = prod_code(p);
        return c[DIG_W*(N_DIG-1-k) +: DIG_W];
    endfunction

    typedef struct packed {
        phase_e              phase;
        logic [POS_W-1:0]    pos;
        digit_t              digit;
        mask_t               mask;
        logic [IDX_W-1:0]    idx;
        logic [PRICE_W-1:0]  price;
        logic [QTY_W-1:0]    qty;
        logic                add;
        logic                invalid;
    } entry_state_t;

endpackage

// File: rtl/wrap_step.sv
module wrap_step #(
    parameter int W      = 4,
    parameter int LO_VAL = 0,
    parameter int HI_VAL = 9
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (val >= W'(HI_VAL)) begin
            nxt = W'(LO_VAL);
        end else begin
            nxt = val + W'(1);
        end
    end
endmodule

// File: rtl/code_prefix_match.sv
module code_prefix_match
    import prodcode_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  digit_t           digit,
    input  mask_t            mask_in,
    output mask_t            mask_out
);
    for (genvar p = 0; p < N_PROD; p++) begin : g_prod
        assign mask_out[p] = mask_in[p] & (prod_digit(p, int'(pos)) == digit);
    end
endmodule

// File: rtl/hit_encoder.sv
module hit_encoder
    import prodcode_pkg::*;
(
    input  mask_t               mask,
    output logic                any,
    output logic [IDX_W-1:0]    idx,
    output logic [PRICE_W-1:0]  price
);
    // Codes are unique, so a complete match has at most one bit set and
    // OR-merging the selected entries gives that entry alone.
    always_comb begin
        idx   = '0;
        price = '0;
        for (int p = 0; p < N_PROD; p++) begin
            if (mask[p]) begin
                idx   = idx | IDX_W'(p);
                price = price | prod_price(p);
            end
        end
        any = |mask;
    end
endmodule

// File: rtl/prodcode_entry.sv
module prodcode_entry
    import prodcode_pkg::*;
#(
    parameter int DIG_MAX = 9,
    parameter int QTY_MIN = 1,
    parameter int QTY_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                btn_inc,
    input  logic                btn_next,
    input  logic                btn_clear,
    output logic [DIG_W-1:0]    cur_digit,
    output logic [POS_W-1:0]    digit_pos,
    output logic [N_PROD-1:0]   match_mask,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_index,
    output logic [PRICE_W-1:0]  hit_price,
    output logic [QTY_W-1:0]    qty,
    output logic                invalid,
    output logic                add_valid,
    output logic [IDX_W-1:0]    add_index,
    output logic [QTY_W-1:0]    add_qty
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_DIG - 1);

    entry_state_t st_d, st_q;

    mask_t               mask_new;
    logic                enc_any;
    logic [IDX_W-1:0]    enc_idx;
    logic [PRICE_W-1:0]  enc_price;
    digit_t              digit_inc;
    logic [QTY_W-1:0]    qty_inc;

    code_prefix_match u_match (
        .pos      (st_q.pos),
        .digit    (st_q.digit),
        .mask_in  (st_q.mask),
        .mask_out (mask_new)
    );

    hit_encoder u_enc (
        .mask  (mask_new),
        .any   (enc_any),
        .idx   (enc_idx),
        .price (enc_price)
    );

    wrap_step #(.W(DIG_W), .LO_VAL(0), .HI_VAL(DIG_MAX)) u_dig_step (
        .val (st_q.digit),
        .nxt (digit_inc)
    );

    wrap_step #(.W(QTY_W), .LO_VAL(QTY_MIN), .HI_VAL(QTY_MAX)) u_qty_step (
        .val (st_q.qty),
        .nxt (qty_inc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.add     = 1'b0;
        st_d.invalid = 1'b0;
        if (btn_clear) begin
            st_d.phase = PH_CODE;
            st_d.pos   = '0;
            st_d.digit = '0;
            st_d.mask  = '1;
            st_d.idx   = '0;
            st_d.price = '0;
            st_d.qty   = '0;
        end else if (st_q.phase == PH_CODE) begin
            if (btn_next) begin
                st_d.digit = '0;
                if (st_q.pos == LAST_POS) begin
                    st_d.pos = '0;
                    if (enc_any) begin
                        st_d.phase = PH_QTY;
                        st_d.mask  = mask_new;
                        st_d.idx   = enc_idx;
                        st_d.price = enc_price;
                        st_d.qty   = QTY_W'(QTY_MIN);
                    end else begin
                        st_d.invalid = 1'b1;
                        st_d.mask    = '1;
                    end
                end else begin
                    st_d.pos  = st_q.pos + POS_W'(1);
                    st_d.mask = mask_new;
                end
            end else if (btn_inc) begin
                st_d.digit = digit_inc;
            end
        end else begin
            if (btn_next) begin
                st_d.add   = 1'b1;
                st_d.phase = PH_CODE;
                st_d.pos   = '0;
                st_d.digit = '0;
                st_d.mask  = '1;
            end else if (btn_inc) begin
                st_d.qty = qty_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= PH_CODE;
            st_q.pos     <= '0;
            st_q.digit   <= '0;
            st_q.mask    <= '1;
            st_q.idx     <= '0;
            st_q.price   <= '0;
            st_q.qty     <= '0;
            st_q.add     <= 1'b0;
            st_q.invalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_digit  = st_q.digit;
    assign digit_pos  = st_q.pos;
    assign match_mask = st_q.mask;
    assign hit        = (st_q.phase == PH_QTY);
    assign hit_index  = st_q.idx;
    assign hit_price  = st_q.price;
    assign qty        = st_q.qty;
    assign invalid    = st_q.invalid;
    assign add_valid  = st_q.add;
    assign add_index  = st_q.idx;
    assign add_qty    = st_q.qty;

endmodule

// File: rtl/prodcode_entry_chk.sv
module prodcode_entry_chk
    import prodcode_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                btn_inc,
    input logic                btn_next,
    input logic                btn_clear,
    input logic [DIG_W-1:0]    cur_digit,
    input logic [POS_W-1:0]    digit_pos,
    input logic [N_PROD-1:0]   match_mask,
    input logic                hit,
    input logic [IDX_W-1:0]    hit_index,
    input logic [PRICE_W-1:0]  hit_price,
    input logic [QTY_W-1:0]    qty,
    input logic                invalid,
    input logic                add_valid,
    input logic [IDX_W-1:0]    add_index,
    input logic [QTY_W-1:0]    add_qty
);
    localparam mask_t ALL_ONES = '1;

    // R2: edited digit stays decimal
    p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_digit <= DIG_W'(9));

    // R3: mask only shrinks while a code is partly entered
    p_mask_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_pos != '0) |-> ((match_mask & ~$past(match_mask)) == '0));

    // R4: identified product is unique
    p_hit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($countones(match_mask) == 1));

    // R5: invalid pulse comes with a restarted entry
    p_invalid_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (match_mask == ALL_ONES && digit_pos == '0 && !hit));

    // R5: invalid lasts one cycle
    p_invalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |=> !invalid);

    // R6: quantity range while choosing
    p_qty_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (qty >= QTY_W'(1) && qty <= QTY_W'(9)));

    // R7: add request is a single pulse leaving the quantity step
    p_add_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        add_valid |=> !add_valid);

    p_add_from_qty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        add_valid |-> ($past(hit) && !hit && match_mask == ALL_ONES));

    // R8: clear restarts everything
    p_clear_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(btn_clear) |-> (!hit && !add_valid && !invalid &&
                              match_mask == ALL_ONES && digit_pos == '0));

endmodule

bind prodcode_entry prodcode_entry_chk u_chk (.*);

// File: tb/tb_prodcode_entry.sv
module tb_prodcode_entry;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn_inc = 1'b0, btn_next = 1'b0, btn_clear = 1'b0;
    logic [3:0]  cur_digit;
    logic [1:0]  digit_pos;
    logic [11:0] match_mask;
    logic        hit;
    logic [3:0]  hit_index;
    logic [9:0]  hit_price;
    logic [3:0]  qty;
    logic        invalid;
    logic        add_valid;
    logic [3:0]  add_index;
    logic [3:0]  add_qty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int codes[12]  = '{1234, 1243, 1324, 1342, 2134, 2143, 2314, 3124, 3142, 3412, 4123, 4133};
    int prices[12] = '{50, 125, 199, 240, 315, 399, 450, 525, 610, 735, 850, 995};

    always #4 clk = ~clk;

    prodcode_entry dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dec_digit(int code, int k);
        int div = 1;
        for (int j = 0; j < 3 - k; j++) div = div * 10;
        return (code / div) % 10;
    endfunction

    // Mask of products whose first n digits equal entered[0..n-1]
    function automatic int exp_mask(int entered[4], int n);
        int m = 0;
        for (int p = 0; p < 12; p++) begin
            bit ok = 1'b1;
            for (int k = 0; k < n; k++)
                if (dec_digit(codes[p], k) != entered[k]) ok = 1'b0;
            if (ok) m = m | (1 << p);
        end
        return m;
    endfunction

    task automatic press(bit i, bit n, bit c);
        @(negedge clk);
        btn_inc = i; btn_next = n; btn_clear = c;
        @(negedge clk);
        btn_inc = 1'b0; btn_next = 1'b0; btn_clear = 1'b0;
    endtask

    task automatic enter_digit(int d);
        for (int j = 0; j < d; j++) press(1, 0, 0);
        press(0, 1, 0);
    endtask

    initial begin
        int ent[4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 digit", cur_digit, 0);
        chk("R1 pos", digit_pos, 0);
        chk("R1 mask", match_mask, 12'hFFF);
        chk("R1 hit", hit, 0);
        chk("R1 qty", qty, 0);
        chk("R1 index", hit_index, 0);
        chk("R1 price", hit_price, 0);
        chk("R1 invalid", invalid, 0);
        chk("R1 add", add_valid, 0);

        // R2 wrap
        for (int j = 0; j < 9; j++) press(1, 0, 0);
        chk("R2 digit at 9", cur_digit, 9);
        press(1, 0, 0);
        chk("R2 wrap to 0", cur_digit, 0);

        // R3 sweep of every two-digit prefix
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                press(0, 0, 1);
                ent[0] = a; ent[1] = b;
                enter_digit(a);
                chk("R3 mask d0", match_mask, exp_mask(ent, 1));
                chk("R3 pos d0", digit_pos, 1);
                chk("R3 digit reset", cur_digit, 0);
                enter_digit(b);
                chk("R3 mask d1", match_mask, exp_mask(ent, 2));
                chk("R3 pos d1", digit_pos, 2);
            end
        end

        // R4 / R6 / R7 every product
        for (int p = 0; p < 12; p++) begin
            press(0, 0, 1);
            for (int k = 0; k < 4; k++) begin
                ent[k] = dec_digit(codes[p], k);
                enter_digit(ent[k]);
                if (k < 3) chk("R3 mask", match_mask, exp_mask(ent, k + 1));
            end
            chk("R4 hit", hit, 1);
            chk("R4 mask", match_mask, 1 << p);
            chk("R4 index", hit_index, p);
            chk("R4 price", hit_price, prices[p]);
            chk("R4 qty", qty, 1);
            chk("R4 pos", digit_pos, 0);
            for (int j = 0; j < p % 9; j++) press(1, 0, 0);
            chk("R6 qty step", qty, p % 9 + 1);
            press(0, 1, 0);
            chk("R7 add", add_valid, 1);
            chk("R7 add index", add_index, p);
            chk("R7 add qty", add_qty, p % 9 + 1);
            chk("R7 hit drop", hit, 0);
            chk("R7 mask", match_mask, 12'hFFF);
            @(negedge clk);
            chk("R7 one cycle", add_valid, 0);
        end

        // R6 wrap 9 -> 1
        press(0, 0, 1);
        enter_digit(4); enter_digit(1); enter_digit(3); enter_digit(3);
        chk("R4 last index", hit_index, 11);
        for (int j = 0; j < 8; j++) press(1, 0, 0);
        chk("R6 qty 9", qty, 9);
        press(1, 0, 0);
        chk("R6 wrap to 1", qty, 1);

        // R8 clear in quantity step
        press(0, 0, 1);
        chk("R8 hit", hit, 0);
        chk("R8 add", add_valid, 0);
        chk("R8 mask", match_mask, 12'hFFF);
        chk("R8 qty", qty, 0);
        // R8 clear mid-entry
        enter_digit(1); enter_digit(2); press(1, 0, 0);
        press(0, 0, 1);
        chk("R8 pos", digit_pos, 0);
        chk("R8 digit", cur_digit, 0);
        chk("R8 mask mid", match_mask, 12'hFFF);
        chk("R8 invalid", invalid, 0);

        // R5 complete codes matching nothing
        begin
            int bad[6] = '{0, 1235, 4134, 9999, 2222, 1230};
            for (int b = 0; b < 6; b++) begin
                press(0, 0, 1);
                for (int k = 0; k < 4; k++) enter_digit(dec_digit(bad[b], k));
                chk("R5 invalid", invalid, 1);
                chk("R5 pos", digit_pos, 0);
                chk("R5 mask", match_mask, 12'hFFF);
                chk("R5 hit", hit, 0);
                @(negedge clk);
                chk("R5 one cycle", invalid, 0);
            end
        end

        // R9 priority
        press(0, 0, 1);
        for (int j = 0; j < 3; j++) press(1, 0, 0);
        press(1, 1, 0);
        chk("R9 next over inc pos", digit_pos, 1);
        chk("R9 next over inc digit", cur_digit, 0);
        ent[0] = 3;
        chk("R9 next over inc mask", match_mask, exp_mask(ent, 1));
        press(1, 1, 1);
        chk("R9 clear over next pos", digit_pos, 0);
        chk("R9 clear over next mask", match_mask, 12'hFFF);
        enter_digit(2); enter_digit(1); enter_digit(3); enter_digit(4);
        chk("R9 hit", hit_index, 4);
        press(1, 1, 0);
        chk("R9 add over inc", add_valid, 1);
        chk("R9 qty kept", add_qty, 1);
        enter_digit(2); enter_digit(1); enter_digit(3); enter_digit(4);
        press(0, 1, 1);
        chk("R9 clear over add", add_valid, 0);
        chk("R9 clear hit", hit, 0);

        // R10 table price sweep already done; spot check index 0 price
        press(0, 0, 1);
        enter_digit(1); enter_digit(2); enter_digit(3); enter_digit(4);
        chk("R10 first price", hit_price, 50);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule